// File: doc/BRIEF.md
# E1 Error Performance Counter Bank

This block gathers the error events that an E1 receiver reports and keeps a running count of each kind: E-bit errors, bipolar violations, CRC-4 errors (fed by one strobe per submultiframe), FAS errors, PRBS bit errors, and loss of basic frame. The loss-of-frame count advances once per 125 µs frame tick while the frame-sync-loss flag is high. Every counter flags an event status bit when it moves and an overflow status bit when it wraps. Software reads the status bits and clears them by reading.

A timer counts frame ticks and marks a one-second boundary. At that boundary four of the counters (E-bit, bipolar violation, CRC-4, FAS) are copied into held snapshot registers, and a one-second status bit is raised. When automatic clearing is enabled, all live counters restart at zero at the boundary. Software can also clear the live counters by moving a control bit from 0 to 1. A single interrupt line combines every status bit with its enable bit.

Access is through a flat register port: a 4-bit address, a write strobe with data, and a read strobe. Read data is combinational from the address, and the read strobe marks a status-clearing read.

Top module: `e1_perf_mon`

## Requirements
- R1: After reset, all live counters, snapshots, status bits, enable bits and control bits read 0, and `irq` is 0.
- R2: The E-bit (index 0), bipolar violation (index 1), FAS (index 3) and PRBS (index 4) counters each rise by one for every cycle in which their strobe is high. They wrap modulo 2^CNT_W.
- R3: The CRC-4 counter (index 2) rises, in one cycle, by the number of its two submultiframe strobes that are high (0, 1 or 2). It wraps modulo 2^CNT_W.
- R4: The loss-of-frame counter (index 5) rises by one on a cycle with both `frame_tick` and `sync_lost` high. `sync_lost` without `frame_tick` has no effect.
- R5: Event status bit i is set in any cycle in which counter i increases. Overflow status bit i is set when that increase carries counter i past its maximum value.
- R6: A status register returns its bits while `reg_rd` is high at its address, and those bits clear at that clock edge. A bit set by an event in the same cycle remains set.
- R7: Writing control bit 0 as 1 while it holds 0 clears all six live counters. Writing 1 while it already holds 1 changes no count, and the snapshots are never touched. An event in the same cycle as the clear is counted after the clear.
- R8: On every SEC_TICKS-th frame tick, the four snapshot registers take the live counts of counters 0 to 3 as they stood before that cycle, and the one-second status bit is set. Between boundaries the snapshots hold.
- R9: With control bit 1 set, all live counters restart at the one-second boundary, and an event in that same cycle counts into the new interval. With control bit 1 clear, counting continues across the boundary.
- R10: `irq` is high exactly when some event status bit has its event-enable bit set, some overflow status bit has its overflow-enable bit set, or the one-second bit is set with control bit 2 set. An enable bit of 0 hides a status bit from `irq` but not from a read.
- R11: The address map is as follows. 0 holds control, with bit 0 as the clear request, bit 1 as automatic clearing and bit 2 as the one-second enable. 1 to 6 hold live counters 0 to 5. 7 to 10 hold snapshots of counters 0 to 3. 11 holds event status, 12 holds overflow status, 13 holds the event enables and 14 holds the overflow enables, all six-bit fields with bit i for counter i. 15 holds the one-second status in bit 0. Only 0, 13 and 14 are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_ebit | input | 1 | E-bit error strobe |
| ev_bpv | input | 1 | Bipolar violation strobe |
| ev_crc_a | input | 1 | CRC-4 error strobe, first submultiframe |
| ev_crc_b | input | 1 | CRC-4 error strobe, second submultiframe |
| ev_fas | input | 1 | FAS error strobe |
| ev_prbs | input | 1 | PRBS bit error strobe |
| sync_lost | input | 1 | Basic frame sync lost flag (level) |
| frame_tick | input | 1 | One-cycle pulse per 125 µs frame |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rd | input | 1 | Status-clearing read strobe |
| reg_rdata | output | REG_W | Read data for `reg_addr` |
| irq | output | 1 | Combined enabled interrupt |

## Verification
A wrong count or a lost increment shows at the ports at once, because every live counter reads combinationally and is compared after each cycle. A status bit that fails to set, clear, or hold shows on the same read, and also on `irq` in the next cycle when its enable is set. A fault in the tick timer or the snapshot path stays hidden until a one-second boundary. The bench therefore uses a short second, so that this delay is a handful of frame ticks, and compares the snapshots on both sides of each boundary.

// File: rtl/e1pm_pkg.sv
`timescale 1ns/1ps
package e1pm_pkg;
   localparam int NCNT   = 6;
   localparam int NLAT   = 4;
   localparam int ADDR_W = 4;
   localparam int INC_W  = 2;

   localparam int IX_EBIT = 0;
   localparam int IX_BPV  = 1;
   localparam int IX_CRC  = 2;
   localparam int IX_FAS  = 3;
   localparam int IX_PRBS = 4;
   localparam int IX_LOBF = 5;

   localparam int A_CTRL  = 0;
   localparam int A_LIVE0 = 1;
   localparam int A_LAT0  = 7;
   localparam int A_EVT   = 11;
   localparam int A_OVF   = 12;
   localparam int A_EMSK  = 13;
   localparam int A_OMSK  = 14;
   localparam int A_SEC   = 15;

   localparam int C_CLR   = 0;
   localparam int C_AUTO  = 1;
   localparam int C_SECEN = 2;
   localparam int CTRL_W  = 3;
endpackage

// File: rtl/e1pm_counter.sv
`timescale 1ns/1ps
module e1pm_counter #(
   parameter int W     = 8,
   parameter int INC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [W-1:0]     count,
   output logic             wrap
);
   localparam int SW = W + 1;

   if (W < INC_W) begin : g_bad_w
      $error("e1pm_counter: W must be at least INC_W");
   end

   logic [W-1:0]  base;
   logic [SW-1:0] sum;

   always_comb begin
      base = clr ? '0 : count;
      sum  = SW'(base) + SW'(inc);
      wrap = sum[W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= sum[W-1:0];
   end
endmodule

// File: rtl/e1pm_sec_timer.sv
`timescale 1ns/1ps
module e1pm_sec_timer #(
   parameter int TICKS = 8000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic sec_pulse
);
   localparam int TW = (TICKS > 2) ? $clog2(TICKS) : 1;
   localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

   if (TICKS < 2) begin : g_bad_ticks
      $error("e1pm_sec_timer: TICKS must be at least 2");
   end

   logic [TW-1:0] cnt;

   assign sec_pulse = tick && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (sec_pulse) cnt <= '0;
      else if (tick)      cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/e1pm_sticky.sv
`timescale 1ns/1ps
module e1pm_sticky #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         rd_clr,
   output logic [N-1:0] status
);
   if (N < 1) begin : g_bad_n
      $error("e1pm_sticky: N must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (rd_clr ? '0 : status) | set;
   end
endmodule

// File: rtl/e1_perf_mon.sv
`timescale 1ns/1ps
module e1_perf_mon
   import e1pm_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int REG_W     = 16,
   parameter int SEC_TICKS = 8000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_ebit,
   input  logic             ev_bpv,
   input  logic             ev_crc_a,
   input  logic             ev_crc_b,
   input  logic             ev_fas,
   input  logic             ev_prbs,
   input  logic             sync_lost,
   input  logic             frame_tick,
   input  logic [3:0]       reg_addr,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             reg_rd,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq
);
   localparam int LIVE_FW = NCNT * CNT_W;
   localparam int LAT_FW  = NLAT * CNT_W;

   if (CNT_W < INC_W || CNT_W > REG_W) begin : g_bad_cnt_w
      $error("e1_perf_mon: CNT_W must lie between INC_W and REG_W");
   end
   if (REG_W < NCNT) begin : g_bad_reg_w
      $error("e1_perf_mon: REG_W must hold one bit per counter");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [NCNT-1:0]   emsk_q, omsk_q;
   logic              wr_ctrl, clr_pulse, sec_pulse, live_clr;
   logic [INC_W-1:0]  inc [NCNT];
   logic [CNT_W-1:0]  live [NCNT];
   logic [CNT_W-1:0]  lat  [NLAT];
   logic [NCNT-1:0]   wrap, evt_set;
   logic [NCNT-1:0]   evt_st, ovf_st;
   logic              sec_st;
   logic [LIVE_FW-1:0] live_flat;
   logic [LAT_FW-1:0]  lat_flat;
   logic [REG_W-1:0]   unused_wdata;

   assign unused_wdata = reg_wdata;

   // control register and the rising-edge clear request
   assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
   assign clr_pulse = wr_ctrl && reg_wdata[C_CLR] && !ctrl_q[C_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         emsk_q <= '0;
         omsk_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(A_CTRL)) ctrl_q <= reg_wdata[CTRL_W-1:0];
         if (reg_addr == ADDR_W'(A_EMSK)) emsk_q <= reg_wdata[NCNT-1:0];
         if (reg_addr == ADDR_W'(A_OMSK)) omsk_q <= reg_wdata[NCNT-1:0];
      end
   end

   e1pm_sec_timer #(.TICKS(SEC_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(frame_tick), .sec_pulse(sec_pulse)
   );

   assign live_clr = clr_pulse || (sec_pulse && ctrl_q[C_AUTO]);

   // per-counter increment amounts
   always_comb begin
      inc[IX_EBIT] = INC_W'(ev_ebit);
      inc[IX_BPV]  = INC_W'(ev_bpv);
      inc[IX_CRC]  = INC_W'(ev_crc_a) + INC_W'(ev_crc_b);
      inc[IX_FAS]  = INC_W'(ev_fas);
      inc[IX_PRBS] = INC_W'(ev_prbs);
      inc[IX_LOBF] = INC_W'(frame_tick && sync_lost);
   end

   for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      e1pm_counter #(.W(CNT_W), .INC_W(INC_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr(live_clr),
         .inc(inc[i]), .count(live[i]), .wrap(wrap[i])
      );
      assign evt_set[i] = |inc[i];
      assign live_flat[i*CNT_W +: CNT_W] = live[i];
   end

   for (genvar j = 0; j < NLAT; j++) begin : g_lat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         lat[j] <= '0;
         else if (sec_pulse) lat[j] <= live[j];
      end
      assign lat_flat[j*CNT_W +: CNT_W] = lat[j];
   end

   e1pm_sticky #(.N(NCNT)) u_evt (
      .clk(clk), .rst_n(rst_n), .set(evt_set),
      .rd_clr(reg_rd && (reg_addr == ADDR_W'(A_EVT))), .status(evt_st)
   );
   e1pm_sticky #(.N(NCNT)) u_ovf (
      .clk(clk), .rst_n(rst_n), .set(wrap),
      .rd_clr(reg_rd && (reg_addr == ADDR_W'(A_OVF))), .status(ovf_st)
   );
   e1pm_sticky #(.N(1)) u_sec (
      .clk(clk), .rst_n(rst_n), .set(sec_pulse),
      .rd_clr(reg_rd && (reg_addr == ADDR_W'(A_SEC))), .status(sec_st)
   );

   assign irq = (|(evt_st & emsk_q)) || (|(ovf_st & omsk_q))
              || (sec_st && ctrl_q[C_SECEN]);

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_CTRL): reg_rdata = REG_W'(ctrl_q);
         ADDR_W'(A_EVT):  reg_rdata = REG_W'(evt_st);
         ADDR_W'(A_OVF):  reg_rdata = REG_W'(ovf_st);
         ADDR_W'(A_EMSK): reg_rdata = REG_W'(emsk_q);
         ADDR_W'(A_OMSK): reg_rdata = REG_W'(omsk_q);
         ADDR_W'(A_SEC):  reg_rdata = REG_W'(sec_st);
         default:         reg_rdata = '0;
      endcase
      for (int i = 0; i < NCNT; i++)
         if (reg_addr == ADDR_W'(A_LIVE0 + i)) reg_rdata = REG_W'(live[i]);
      for (int j = 0; j < NLAT; j++)
         if (reg_addr == ADDR_W'(A_LAT0 + j)) reg_rdata = REG_W'(lat[j]);
   end
endmodule

module e1_perf_mon_chk #(
   parameter int CNT_W = 8,
   parameter int NCNT  = 6,
   parameter int NLAT  = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  frame_tick,
   input logic [3:0]            reg_addr,
   input logic                  reg_wr,
   input logic                  wr_clr_bit,
   input logic                  reg_rd,
   input logic                  irq,
   input logic [2:0]            ctrl_q,
   input logic                  sec_pulse,
   input logic [NCNT*CNT_W-1:0] live_flat,
   input logic [NLAT*CNT_W-1:0] lat_flat,
   input logic [NCNT-1:0]       evt_st,
   input logic [NCNT-1:0]       emsk_q,
   input logic [NCNT-1:0]       omsk_q,
   input logic                  sec_st
);
   function automatic logic all_small(input logic [NCNT*CNT_W-1:0] v);
      logic ok = 1'b1;
      for (int i = 0; i < NCNT; i++)
         if (v[i*CNT_W +: CNT_W] > CNT_W'(2)) ok = 1'b0;
      return ok;
   endfunction

   logic [CNT_W-1:0] lobf_now;
   assign lobf_now = live_flat[(NCNT-1)*CNT_W +: CNT_W];

   AST_CLR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 4'd0 && wr_clr_bit && !ctrl_q[0]) |=> all_small(live_flat)); // R7
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_pulse |=> $stable(lat_flat)); // R8
   AST_SEC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> sec_st); // R8
   AST_SEC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> !sec_pulse); // R8
   AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && ctrl_q[1]) |=> all_small(live_flat)); // R9
   AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_addr == 4'd11) |=> ((evt_st & $past(evt_st)) == $past(evt_st))); // R6
   AST_LOBF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> (lobf_now <= $past(lobf_now))); // R4
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (emsk_q == '0 && omsk_q == '0 && !ctrl_q[2]) |-> !irq); // R10
endmodule

bind e1_perf_mon e1_perf_mon_chk #(.CNT_W(CNT_W), .NCNT(e1pm_pkg::NCNT), .NLAT(e1pm_pkg::NLAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .reg_addr(reg_addr),
   .reg_wr(reg_wr), .wr_clr_bit(reg_wdata[0]), .reg_rd(reg_rd), .irq(irq),
   .ctrl_q(ctrl_q), .sec_pulse(sec_pulse), .live_flat(live_flat),
   .lat_flat(lat_flat), .evt_st(evt_st), .emsk_q(emsk_q), .omsk_q(omsk_q),
   .sec_st(sec_st)
);

// File: tb/sim_e1_perf_mon.sv
`timescale 1ns/1ps
module sim_e1_perf_mon;
   localparam int CW   = 4;
   localparam int RW   = 16;
   localparam int SECT = 8;
   localparam int MOD  = 1 << CW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_ebit = 0, ev_bpv = 0, ev_crc_a = 0, ev_crc_b = 0;
   logic ev_fas = 0, ev_prbs = 0, sync_lost = 0, frame_tick = 0;
   logic [3:0]    reg_addr = '0;
   logic          reg_wr = 0, reg_rd = 0;
   logic [RW-1:0] reg_wdata = '0;
   logic [RW-1:0] reg_rdata;
   logic          irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   int m_cnt [6];
   int m_lat [4];
   logic [5:0] m_evt = '0, m_ovf = '0, m_emsk = '0, m_omsk = '0;
   logic       m_sec = 0;
   logic [2:0] m_ctrl = '0;
   int         m_secc = 0;

   always #5 clk = ~clk;

   e1_perf_mon #(.CNT_W(CW), .REG_W(RW), .SEC_TICKS(SECT)) u0 (
      .clk(clk), .rst_n(rst_n), .ev_ebit(ev_ebit), .ev_bpv(ev_bpv),
      .ev_crc_a(ev_crc_a), .ev_crc_b(ev_crc_b), .ev_fas(ev_fas),
      .ev_prbs(ev_prbs), .sync_lost(sync_lost), .frame_tick(frame_tick),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(string tag, string what, logic [RW-1:0] got, logic [RW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic logic [RW-1:0] model_reg(int a);
      if (a == 0)              return RW'(m_ctrl);
      if (a >= 1 && a <= 6)    return RW'(m_cnt[a-1]);
      if (a >= 7 && a <= 10)   return RW'(m_lat[a-7]);
      if (a == 11)             return RW'(m_evt);
      if (a == 12)             return RW'(m_ovf);
      if (a == 13)             return RW'(m_emsk);
      if (a == 14)             return RW'(m_omsk);
      return RW'(m_sec);
   endfunction

   function automatic logic model_irq();
      return (|(m_evt & m_emsk)) || (|(m_ovf & m_omsk)) || (m_sec && m_ctrl[2]);
   endfunction

   // every register plus irq, no strobes active
   task automatic check_all(string tag);
      for (int a = 0; a < 16; a++) begin
         reg_addr = 4'(a);
         #0.2;
         check(tag, $sformatf("reg%0d", a), reg_rdata, model_reg(a));
      end
      check(tag, "irq", RW'(irq), RW'(model_irq()));
   endtask

   // ev: 0 ebit,1 bpv,2 crc_a,3 crc_b,4 fas,5 prbs,6 sync_lost,7 frame_tick
   task automatic step(logic [7:0] ev);
      int inc [6];
      bit sec, clrp, zap;
      int s;
      logic [5:0] eset, oset;
      {frame_tick, sync_lost, ev_prbs, ev_fas, ev_crc_b, ev_crc_a, ev_bpv, ev_ebit} = ev;
      inc[0] = int'(ev[0]); inc[1] = int'(ev[1]);
      inc[2] = int'(ev[2]) + int'(ev[3]);
      inc[3] = int'(ev[4]); inc[4] = int'(ev[5]);
      inc[5] = int'(ev[6] && ev[7]);
      sec  = ev[7] && (m_secc == SECT - 1);
      clrp = reg_wr && reg_addr == 4'd0 && reg_wdata[0] && !m_ctrl[0];
      zap  = clrp || (sec && m_ctrl[1]);
      if (sec) for (int j = 0; j < 4; j++) m_lat[j] = m_cnt[j];
      for (int i = 0; i < 6; i++) begin
         s = (zap ? 0 : m_cnt[i]) + inc[i];
         eset[i] = inc[i] != 0;
         oset[i] = s >= MOD;
         m_cnt[i] = s % MOD;
      end
      if (ev[7]) m_secc = sec ? 0 : m_secc + 1;
      m_evt = ((reg_rd && reg_addr == 4'd11) ? 6'd0 : m_evt) | eset;
      m_ovf = ((reg_rd && reg_addr == 4'd12) ? 6'd0 : m_ovf) | oset;
      m_sec = ((reg_rd && reg_addr == 4'd15) ? 1'b0 : m_sec) | sec;
      if (reg_wr) begin
         if (reg_addr == 4'd0)  m_ctrl = reg_wdata[2:0];
         if (reg_addr == 4'd13) m_emsk = reg_wdata[5:0];
         if (reg_addr == 4'd14) m_omsk = reg_wdata[5:0];
      end
      @(posedge clk); #1;
      {frame_tick, sync_lost, ev_prbs, ev_fas, ev_crc_b, ev_crc_a, ev_bpv, ev_ebit} = '0;
      reg_wr = 0; reg_rd = 0;
   endtask

   task automatic wr(int a, logic [RW-1:0] d, logic [7:0] ev);
      reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
      step(ev);
   endtask

   task automatic rd_clr(string tag, int a, logic [7:0] ev);
      reg_addr = 4'(a);
      #0.2;
      check(tag, $sformatf("read-clear reg%0d", a), reg_rdata, model_reg(a));
      reg_rd = 1;
      step(ev);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 6; i++) m_cnt[i] = 0;
      for (int j = 0; j < 4; j++) m_lat[j] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      check_all("R1");
      check_all("R11");

      // R2: single-strobe counters through more than one wrap
      for (int k = 0; k < 2*MOD + 3; k++) begin
         step(8'h01); check_all("R2");
      end
      for (int k = 0; k < MOD + 1; k++) step(8'h32);
      check_all("R2");

      // R6: read-clear, with a coincident event that must survive
      rd_clr("R6", 11, 8'h00); check_all("R6");
      step(8'h02);
      rd_clr("R6", 11, 8'h02); check_all("R6");
      rd_clr("R6", 12, 8'h00); check_all("R6");

      // R3: crc strobes alone and together, across a wrap
      step(8'h04); check_all("R3");
      step(8'h08); check_all("R3");
      for (int k = 0; k < MOD/2 + 1; k++) begin
         step(8'h0C); check_all("R3");
      end

      // R4: sync_lost without tick, tick without sync_lost, both
      step(8'h40); check_all("R4");
      step(8'h80); check_all("R4");
      step(8'hC0); check_all("R4");

      // R7: rising clear, repeated 1, re-arm, clear with event in same cycle
      for (int k = 0; k < 5; k++) step(8'h3F);
      wr(0, 16'h0001, 8'h00); check_all("R7");
      for (int k = 0; k < 3; k++) step(8'h3F);
      wr(0, 16'h0001, 8'h00); check_all("R7");
      wr(0, 16'h0000, 8'h00); check_all("R7");
      wr(0, 16'h0001, 8'h0D); check_all("R7");

      // R8: boundaries without auto-clear, events on the boundary tick
      wr(0, 16'h0000, 8'h00);
      for (int k = 0; k < 3*SECT; k++) begin
         step(8'h9F); check_all("R8");
      end
      rd_clr("R8", 15, 8'h00); check_all("R8");

      // R9: auto-clear at boundaries
      wr(0, 16'h0002, 8'h00);
      for (int k = 0; k < 2*SECT + 2; k++) begin
         step(8'hFF); check_all("R9");
      end

      // R10: enables one at a time against live status
      wr(0, 16'h0002, 8'h00);
      rd_clr("R10", 11, 8'h00); rd_clr("R10", 12, 8'h00); rd_clr("R10", 15, 8'h00);
      check_all("R10");
      for (int b = 0; b < 6; b++) begin
         wr(13, RW'(1 << b), 8'h00); check_all("R10");
         step(8'(1 << b)); check_all("R10");
         rd_clr("R10", 11, 8'h00); check_all("R10");
      end
      wr(13, 16'h0000, 8'h00);
      wr(14, 16'h0004, 8'h00);
      for (int k = 0; k < MOD; k++) step(8'h04);
      check_all("R10");
      wr(14, 16'h0000, 8'h00); check_all("R10");
      wr(0, 16'h0004, 8'h00);
      for (int k = 0; k < SECT; k++) step(8'h80);
      check_all("R10");

      // R5: sweep of all strobe patterns with enables and periodic reads
      wr(13, 16'h002A, 8'h00); wr(14, 16'h0015, 8'h00);
      wr(0, 16'h0006, 8'h00);
      for (int v = 0; v < 256; v++) begin
         if (v % 7 == 3) rd_clr("R5", 11, 8'(v));
         else if (v % 11 == 5) rd_clr("R5", 12, 8'(v));
         else step(8'(v));
         check_all("R5");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule